// File: doc/BRIEF.md
# Flash Command Interpreter with Read-Mode Selection

This block sits behind the write port of a parallel NOR flash. Each bus write delivers a command byte and a block address. The block decodes one- and two-cycle command sequences and tracks whether the chip is ready, waiting for a second cycle, busy, suspended, or swallowing a bad sequence. From that it decides what a read returns: array contents, the status byte, or identifier/query data.

Program, erase, OTP and the two buffered programming flows start a write-state-machine stub. The stub counts down a fixed number of cycles and can be frozen while an operation is suspended. Lock-family and blank-check confirms complete at once and return to ready. The block reports each launch, suspend and resume as a one-cycle pulse, and reports the kind of operation launched.

Command bytes: FFh read array, 70h read status, 90h/98h read identifier/query, 50h clear status, 40h word-program setup, C0h OTP setup, 20h erase setup, E8h buffered-program setup, 80h enhanced buffered-program setup, 60h lock/configuration setup, BCh blank-check setup, D0h confirm/resume, B0h suspend, 01h/2Fh/03h/04h lock-family confirms. Every other byte is illegal.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, rd_sel is 0 (array), status is 80h, and op_start, op_suspend and op_resume are low.
- R2: In the ready state, FFh sets rd_sel to 0 (array), 70h sets it to 1 (status), and 90h or 98h set it to 2 (identifier/query). Clear status and D0h/B0h/lock-confirm bytes leave rd_sel unchanged.
- R3: Entering any setup, busy or suspended state sets rd_sel to 1. While busy, FFh still sets rd_sel to 0, and 70h/90h/98h keep working.
- R4: Word program (40h, data), OTP (C0h, data) and erase (20h, D0h) pulse op_start with op_kind 0, 2 and 1 respectively. Status bit 7 then stays low for exactly BUSY_CYC samples. An erase setup followed by any byte other than D0h sets status bits 5 and 4 and starts nothing.
- R5: 60h followed by 01h, 2Fh, D0h, 03h or 04h pulses op_start with op_kind 5 and returns to ready without a busy phase. BCh followed by D0h does the same with op_kind 6. 60h followed by any other byte sets status bits 5 and 4.
- R6: Buffered program is E8h, then two data writes, then D0h, and it starts with op_kind 3. If the second data write carries a block address different from the first, status bit 4 is set, nothing starts, and the block returns to ready.
- R7: Enhanced buffered program is 80h then D0h; the block address of the D0h write is captured. A later data write to that block starts op_kind 4 only while status bit 0 is 0, and status bit 0 is 1 while that write is in progress. A write to another block while bit 0 is 0 returns to ready; while bit 0 is 1, such a write is ignored.
- R8: B0h during a word-program or erase busy phase pulses op_suspend. It sets status bit 2 (program) or bit 6 (erase), sets bit 7, and freezes the stub. A later D0h pulses op_resume, and the remaining busy count continues unchanged.
- R9: If B0h arrives in the same cycle that the stub finishes, the operation completes: no op_suspend pulse occurs, and status reads 80h afterwards.
- R10: 50h clears status bits 5 and 4 only in the ready state. While busy, suspended or in the enhanced data phase it has no effect.
- R11: While suspended, any setup byte (40h, C0h, 20h, E8h, 80h, 60h, BCh) or illegal byte enters a swallow state. The next write is discarded (D0h does not resume), and the block returns to suspended.
- R12: An illegal byte in the ready state enters an illegal state. The next write is discarded, and the block then returns to ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write cycle strobe, one cycle per write |
| wr_data | input | 8 | Command or data byte |
| wr_blk | input | BLK_W | Block address of the write |
| rd_sel | output | 2 | Read path: 0 array, 1 status, 2 identifier/query |
| status | output | 8 | bit7 ready, bit6 erase suspended, bit5 erase/sequence error, bit4 program error, bit2 program suspended, bit0 enhanced write busy |
| op_start | output | 1 | One-cycle pulse when an operation is launched |
| op_kind | output | 3 | Kind of the last launch: 0 word, 1 erase, 2 OTP, 3 buffered, 4 enhanced, 5 lock family, 6 blank check |
| op_suspend | output | 1 | One-cycle suspend pulse |
| op_resume | output | 1 | One-cycle resume pulse |

## Verification
The stub's completion and an incoming suspend command can land on the same clock edge. The bench provokes this by counting cycles from the launch and placing B0h so that it is captured on the edge where the count runs out. It then expects a completed operation: no suspend pulse, and status 80h. One cycle earlier, the same stimulus must suspend, leaving exactly one busy cycle after the resume. That pair of outcomes pins the priority between the two events.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    SEL_ARRAY  = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_IDENT  = 2'd2
  } rd_sel_e;

  typedef enum logic [3:0] {
    ST_READY, ST_PGM_SETUP, ST_OTP_SETUP, ST_ERS_SETUP, ST_LOCK_SETUP,
    ST_BLANK_SETUP, ST_BUF_LOAD1, ST_BUF_LOAD2, ST_BUF_CONF, ST_EBUF_SETUP,
    ST_EBUF_DATA, ST_BUSY, ST_SUSP, ST_ILL, ST_SUSP_ILL
  } cui_state_e;

  typedef enum logic [3:0] {
    CMD_RD_ARRAY, CMD_RD_STATUS, CMD_RD_IDENT, CMD_CLEAR, CMD_PGM, CMD_OTP,
    CMD_ERASE, CMD_BUF, CMD_EBUF, CMD_LOCK_SET, CMD_BLANK, CMD_CONFIRM,
    CMD_SUSPEND, CMD_LOCK_CONF, CMD_BAD
  } cmd_e;

  typedef enum logic [2:0] {
    OP_PGM   = 3'd0,
    OP_ERASE = 3'd1,
    OP_OTP   = 3'd2,
    OP_BUF   = 3'd3,
    OP_EBUF  = 3'd4,
    OP_LOCK  = 3'd5,
    OP_BLANK = 3'd6
  } op_kind_e;

  localparam int SB_READY     = 7;
  localparam int SB_ERS_SUSP  = 6;
  localparam int SB_ERS_ERR   = 5;
  localparam int SB_PGM_ERR   = 4;
  localparam int SB_PGM_SUSP  = 2;
  localparam int SB_EBUF_BUSY = 0;

  function automatic cmd_e classify(input logic [7:0] b);
    case (b)
      8'hFF:        return CMD_RD_ARRAY;
      8'h70:        return CMD_RD_STATUS;
      8'h90, 8'h98: return CMD_RD_IDENT;
      8'h50:        return CMD_CLEAR;
      8'h40:        return CMD_PGM;
      8'hC0:        return CMD_OTP;
      8'h20:        return CMD_ERASE;
      8'hE8:        return CMD_BUF;
      8'h80:        return CMD_EBUF;
      8'h60:        return CMD_LOCK_SET;
      8'hBC:        return CMD_BLANK;
      8'hD0:        return CMD_CONFIRM;
      8'hB0:        return CMD_SUSPEND;
      8'h01, 8'h2F, 8'h03, 8'h04: return CMD_LOCK_CONF;
      default:      return CMD_BAD;
    endcase
  endfunction

  function automatic logic is_read_cmd(input cmd_e c);
    return (c == CMD_RD_ARRAY) || (c == CMD_RD_STATUS) || (c == CMD_RD_IDENT);
  endfunction

  function automatic rd_sel_e read_target(input cmd_e c);
    case (c)
      CMD_RD_ARRAY: return SEL_ARRAY;
      CMD_RD_IDENT: return SEL_IDENT;
      default:      return SEL_STATUS;
    endcase
  endfunction

  function automatic logic is_setup_in_susp(input cmd_e c);
    return (c == CMD_PGM) || (c == CMD_OTP) || (c == CMD_ERASE) || (c == CMD_BUF) ||
           (c == CMD_EBUF) || (c == CMD_LOCK_SET) || (c == CMD_BLANK) || (c == CMD_BAD);
  endfunction

  function automatic logic [7:0] pack_status(
    input logic ready, input logic ers_susp, input logic ers_err,
    input logic pgm_err, input logic pgm_susp, input logic ebuf_busy);
    logic [7:0] s;
    s = 8'h00;
    s[SB_READY]     = ready;
    s[SB_ERS_SUSP]  = ers_susp;
    s[SB_ERS_ERR]   = ers_err;
    s[SB_PGM_ERR]   = pgm_err;
    s[SB_PGM_SUSP]  = pgm_susp;
    s[SB_EBUF_BUSY] = ebuf_busy;
    return s;
  endfunction

endpackage

// File: rtl/flash_cmd_wsm_stub.sv
module flash_cmd_wsm_stub #(
  parameter int BUSY_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic pause,
  output logic active,
  output logic done
);
  localparam int CW = $clog2(BUSY_CYC + 1);
  localparam logic [CW-1:0] LOAD_VAL = CW'(BUSY_CYC);

  logic [CW-1:0] cnt;

  assign active = (cnt != '0) && !pause;
  assign done   = (cnt == CW'(1)) && !pause;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (load)            cnt <= LOAD_VAL;
    else if (cnt != '0 && !pause) cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int BLK_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic [BLK_W-1:0] wr_blk,
  input  logic             wsm_active,
  input  logic             wsm_done,
  output cui_state_e       state,
  output op_kind_e         cur_kind,
  output logic             ev_start,
  output op_kind_e         ev_kind,
  output logic             ev_suspend,
  output logic             ev_resume,
  output logic             ev_clear,
  output logic             ev_seq_err,
  output logic             ev_blk_mismatch,
  output logic             sel_load,
  output rd_sel_e          sel_value,
  output logic             ill_swallow,
  output logic             paused
);
  cui_state_e       nxt;
  cmd_e             cmd;
  logic             blk_cap;
  logic [BLK_W-1:0] blk_q;

  assign paused = (state == ST_SUSP) || (state == ST_SUSP_ILL);

  always_comb begin
    cmd             = classify(wr_data);
    nxt             = state;
    ev_start        = 1'b0;
    ev_kind         = cur_kind;
    ev_suspend      = 1'b0;
    ev_resume       = 1'b0;
    ev_clear        = 1'b0;
    ev_seq_err      = 1'b0;
    ev_blk_mismatch = 1'b0;
    sel_load        = 1'b0;
    sel_value       = SEL_STATUS;
    ill_swallow     = 1'b0;
    blk_cap         = 1'b0;

    case (state)
      ST_READY: if (wr_en) begin
        if (is_read_cmd(cmd)) begin
          sel_load  = 1'b1;
          sel_value = read_target(cmd);
        end
        case (cmd)
          CMD_CLEAR:    ev_clear = 1'b1;
          CMD_PGM:      nxt = ST_PGM_SETUP;
          CMD_OTP:      nxt = ST_OTP_SETUP;
          CMD_ERASE:    nxt = ST_ERS_SETUP;
          CMD_BUF:      nxt = ST_BUF_LOAD1;
          CMD_EBUF:     nxt = ST_EBUF_SETUP;
          CMD_LOCK_SET: nxt = ST_LOCK_SETUP;
          CMD_BLANK:    nxt = ST_BLANK_SETUP;
          CMD_BAD:      nxt = ST_ILL;
          default:      nxt = ST_READY;
        endcase
        if (nxt != ST_READY && nxt != ST_ILL) sel_load = 1'b1;
      end

      ST_PGM_SETUP: if (wr_en) begin
        ev_start = 1'b1; ev_kind = OP_PGM; nxt = ST_BUSY;
      end

      ST_OTP_SETUP: if (wr_en) begin
        ev_start = 1'b1; ev_kind = OP_OTP; nxt = ST_BUSY;
      end

      ST_ERS_SETUP: if (wr_en) begin
        if (cmd == CMD_CONFIRM) begin
          ev_start = 1'b1; ev_kind = OP_ERASE; nxt = ST_BUSY;
        end else begin
          ev_seq_err = 1'b1; nxt = ST_READY;
        end
      end

      ST_LOCK_SETUP: if (wr_en) begin
        if (cmd == CMD_LOCK_CONF || cmd == CMD_CONFIRM) begin
          ev_start = 1'b1; ev_kind = OP_LOCK;
        end else begin
          ev_seq_err = 1'b1;
        end
        nxt = ST_READY;
      end

      ST_BLANK_SETUP: if (wr_en) begin
        if (cmd == CMD_CONFIRM) begin
          ev_start = 1'b1; ev_kind = OP_BLANK;
        end else begin
          ev_seq_err = 1'b1;
        end
        nxt = ST_READY;
      end

      ST_BUF_LOAD1: if (wr_en) begin
        blk_cap = 1'b1; nxt = ST_BUF_LOAD2;
      end

      ST_BUF_LOAD2: if (wr_en) begin
        if (wr_blk != blk_q) begin
          ev_blk_mismatch = 1'b1; nxt = ST_READY;
        end else begin
          nxt = ST_BUF_CONF;
        end
      end

      ST_BUF_CONF: if (wr_en) begin
        if (cmd == CMD_CONFIRM) begin
          ev_start = 1'b1; ev_kind = OP_BUF; nxt = ST_BUSY;
        end else begin
          ev_seq_err = 1'b1; nxt = ST_READY;
        end
      end

      ST_EBUF_SETUP: if (wr_en) begin
        if (cmd == CMD_CONFIRM) begin
          blk_cap = 1'b1; nxt = ST_EBUF_DATA;
        end else begin
          ev_seq_err = 1'b1; nxt = ST_READY;
        end
      end

      ST_EBUF_DATA: if (wr_en && !wsm_active) begin
        if (wr_blk == blk_q) begin
          ev_start = 1'b1; ev_kind = OP_EBUF;
        end else begin
          nxt = ST_READY;
        end
      end

      ST_BUSY: begin
        if (wr_en && is_read_cmd(cmd)) begin
          sel_load  = 1'b1;
          sel_value = read_target(cmd);
        end
        if (wsm_done) begin
          nxt = ST_READY;
        end else if (wr_en && cmd == CMD_SUSPEND &&
                     (cur_kind == OP_PGM || cur_kind == OP_ERASE)) begin
          ev_suspend = 1'b1;
          sel_load   = 1'b1;
          sel_value  = SEL_STATUS;
          nxt        = ST_SUSP;
        end
      end

      ST_SUSP: if (wr_en) begin
        if (is_read_cmd(cmd)) begin
          sel_load  = 1'b1;
          sel_value = read_target(cmd);
        end else if (cmd == CMD_CONFIRM) begin
          ev_resume = 1'b1;
          sel_load  = 1'b1;
          sel_value = SEL_STATUS;
          nxt       = ST_BUSY;
        end else if (is_setup_in_susp(cmd)) begin
          nxt = ST_SUSP_ILL;
        end
      end

      ST_SUSP_ILL: if (wr_en) begin
        ill_swallow = 1'b1; nxt = ST_SUSP;
      end

      ST_ILL: if (wr_en) begin
        ill_swallow = 1'b1; nxt = ST_READY;
      end

      default: nxt = ST_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_READY;
      cur_kind <= OP_PGM;
      blk_q    <= '0;
    end else begin
      state <= nxt;
      if (ev_start) cur_kind <= ev_kind;
      if (blk_cap)  blk_q    <= wr_blk;
    end
  end
endmodule

// File: rtl/flash_cmd_outsel.sv
module flash_cmd_outsel
  import flash_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_load,
  input  rd_sel_e    sel_value,
  input  logic       ev_clear,
  input  logic       ev_seq_err,
  input  logic       ev_blk_mismatch,
  input  logic       ev_start,
  input  op_kind_e   ev_kind,
  input  logic       ev_suspend,
  input  logic       ev_resume,
  input  logic       wsm_active,
  input  logic       ebuf_phase,
  input  logic       susp_erase,
  input  logic       susp_pgm,
  output logic [1:0] rd_sel,
  output logic [7:0] status,
  output logic       op_start,
  output logic [2:0] op_kind,
  output logic       op_suspend,
  output logic       op_resume
);
  rd_sel_e sel_q;
  logic    err_ers, err_pgm;

  assign rd_sel = sel_q;
  assign status = pack_status(!wsm_active, susp_erase, err_ers, err_pgm,
                              susp_pgm, ebuf_phase && wsm_active);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q      <= SEL_ARRAY;
      err_ers    <= 1'b0;
      err_pgm    <= 1'b0;
      op_start   <= 1'b0;
      op_kind    <= 3'd0;
      op_suspend <= 1'b0;
      op_resume  <= 1'b0;
    end else begin
      if (sel_load) sel_q <= sel_value;
      if (ev_clear) begin
        err_ers <= 1'b0;
        err_pgm <= 1'b0;
      end else begin
        if (ev_seq_err)                   err_ers <= 1'b1;
        if (ev_seq_err || ev_blk_mismatch) err_pgm <= 1'b1;
      end
      op_start   <= ev_start;
      if (ev_start) op_kind <= ev_kind;
      op_suspend <= ev_suspend;
      op_resume  <= ev_resume;
    end
  end
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int BLK_W    = 10,
  parameter int BUSY_CYC = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic [BLK_W-1:0] wr_blk,
  output logic [1:0]       rd_sel,
  output logic [7:0]       status,
  output logic             op_start,
  output logic [2:0]       op_kind,
  output logic             op_suspend,
  output logic             op_resume
);
  cui_state_e state;
  op_kind_e   cur_kind, ev_kind;
  rd_sel_e    sel_value;
  logic ev_start, ev_suspend, ev_resume, ev_clear, ev_seq_err, ev_blk_mismatch;
  logic sel_load, ill_swallow, paused;
  logic wsm_active, wsm_done;
  logic susp_erase, susp_pgm, ebuf_phase;

  assign susp_erase = paused && (cur_kind == OP_ERASE);
  assign susp_pgm   = paused && (cur_kind == OP_PGM);
  assign ebuf_phase = (state == ST_EBUF_DATA);

  flash_cmd_wsm_stub #(.BUSY_CYC(BUSY_CYC)) u_wsm (
    .clk(clk), .rst_n(rst_n), .load(ev_start && ev_kind != OP_LOCK && ev_kind != OP_BLANK),
    .pause(paused), .active(wsm_active), .done(wsm_done)
  );

  flash_cmd_fsm #(.BLK_W(BLK_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_blk(wr_blk),
    .wsm_active(wsm_active), .wsm_done(wsm_done), .state(state), .cur_kind(cur_kind),
    .ev_start(ev_start), .ev_kind(ev_kind), .ev_suspend(ev_suspend),
    .ev_resume(ev_resume), .ev_clear(ev_clear), .ev_seq_err(ev_seq_err),
    .ev_blk_mismatch(ev_blk_mismatch), .sel_load(sel_load), .sel_value(sel_value),
    .ill_swallow(ill_swallow), .paused(paused)
  );

  flash_cmd_outsel u_out (
    .clk(clk), .rst_n(rst_n), .sel_load(sel_load), .sel_value(sel_value),
    .ev_clear(ev_clear), .ev_seq_err(ev_seq_err), .ev_blk_mismatch(ev_blk_mismatch),
    .ev_start(ev_start), .ev_kind(ev_kind), .ev_suspend(ev_suspend),
    .ev_resume(ev_resume), .wsm_active(wsm_active), .ebuf_phase(ebuf_phase),
    .susp_erase(susp_erase), .susp_pgm(susp_pgm), .rd_sel(rd_sel), .status(status),
    .op_start(op_start), .op_kind(op_kind), .op_suspend(op_suspend), .op_resume(op_resume)
  );
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] rd_sel,
  input logic [7:0] status,
  input logic       op_start,
  input logic [2:0] op_kind,
  input logic       op_suspend,
  input logic       op_resume,
  input logic       wsm_done,
  input logic       ill_swallow,
  input logic       blk_mismatch
);
  a_r1_reset_array: assert property (@(posedge clk)
    $rose(rst_n) |-> (rd_sel == 2'd0 && status == 8'h80));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({op_start, op_suspend, op_resume}) <= 1);

  a_r9_done_beats_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    wsm_done |=> !op_suspend);

  a_r10_clear_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!status[7] || status[6] || status[2]) |=> status[5:4] == $past(status[5:4]));

  a_r6_mismatch_flag: assert property (@(posedge clk) disable iff (!rst_n)
    blk_mismatch |=> (status[4] && !op_start));

  a_r7_ebuf_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && op_kind == 3'd4) |-> !$past(status[0]));

  a_r11_swallow_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ill_swallow |=> (!op_resume && !op_start));

  a_r4_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && op_kind <= 3'd3) |-> !status[7]);
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk i_chk (
  .clk(clk), .rst_n(rst_n), .rd_sel(rd_sel), .status(status), .op_start(op_start),
  .op_kind(op_kind), .op_suspend(op_suspend), .op_resume(op_resume),
  .wsm_done(wsm_done), .ill_swallow(ill_swallow), .blk_mismatch(ev_blk_mismatch)
);

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int BLK_W      = 10;
  localparam int BUSY       = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [7:0]       wr_data = 8'h00;
  logic [BLK_W-1:0] wr_blk = '0;
  logic [1:0]       rd_sel;
  logic [7:0]       status;
  logic             op_start, op_suspend, op_resume;
  logic [2:0]       op_kind;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  flash_cmd_ctrl #(.BLK_W(BLK_W), .BUSY_CYC(BUSY)) i_flash_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_blk(wr_blk),
    .rd_sel(rd_sel), .status(status), .op_start(op_start), .op_kind(op_kind),
    .op_suspend(op_suspend), .op_resume(op_resume)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  // one write cycle; returns at the negedge after the capturing edge
  task automatic wr(input logic [7:0] d, input logic [BLK_W-1:0] b = '0);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_blk = b;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    for (int i = 0; i < 1000 && !status[7]; i++) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R1 rd_sel", rd_sel, 0);
    chk("R1 status", status, 8'h80);
    chk("R1 pulses", {op_start, op_suspend, op_resume}, 0);
  endtask

  task automatic t_read_modes;
    wr(8'h90); chk("R2 90h ident", rd_sel, 2);
    wr(8'hFF); wr(8'h98); chk("R2 98h ident", rd_sel, 2);
    wr(8'h70); chk("R2 70h status", rd_sel, 1);
    wr(8'h50); chk("R2 50h keeps", rd_sel, 1);
    wr(8'hD0); chk("R2 D0h keeps", rd_sel, 1);
    wr(8'hFF); chk("R2 FFh array", rd_sel, 0);
    wr(8'hB0); chk("R2 B0h keeps", rd_sel, 0);
    wr(8'h2F); chk("R2 2Fh keeps", rd_sel, 0);
  endtask

  task automatic t_busy_reads;
    int n;
    wr(8'h40); chk("R3 setup forces status", rd_sel, 1);
    wr(8'hAA); chk("R4 word start", {op_start, op_kind}, {1'b1, 3'd0});
    chk("R4 busy", status[7], 0);
    wr(8'hFF); chk("R3 FFh while busy", rd_sel, 0);
    wr(8'h90); chk("R3 90h while busy", rd_sel, 2);
    wr(8'h70); chk("R3 70h while busy", rd_sel, 1);
    busy_len(n);
    chk("R4 ready after word", status, 8'h80);
  endtask

  task automatic t_otp_erase;
    int n;
    wr(8'hC0); wr(8'h55);
    chk("R4 OTP start", {op_start, op_kind}, {1'b1, 3'd2});
    busy_len(n); chk("R4 OTP busy length", n, BUSY);
    wr(8'h20); wr(8'hD0);
    chk("R4 erase start", {op_start, op_kind}, {1'b1, 3'd1});
    busy_len(n); chk("R4 erase busy length", n, BUSY);
    wr(8'h20); wr(8'h00);
    chk("R4 erase bad confirm", status, 8'hB0);
    chk("R4 no start", op_start, 0);
  endtask

  task automatic t_clear;
    int n;
    wr(8'h40); wr(8'h12);
    chk("R10 busy keeps errors", status, 8'h30);
    wr(8'h50); chk("R10 clear ignored busy", status[5:4], 2'b11);
    busy_len(n);
    chk("R10 errors after busy", status, 8'hB0);
    wr(8'h50); chk("R10 clear in ready", status, 8'h80);
  endtask

  task automatic t_lock_blank;
    logic [7:0] confs [5] = '{8'h01, 8'h2F, 8'hD0, 8'h03, 8'h04};
    foreach (confs[i]) begin
      wr(8'h60); chk("R3 lock setup status sel", rd_sel, 1);
      wr(confs[i]);
      chk("R5 lock confirm", {op_start, op_kind}, {1'b1, 3'd5});
      chk("R5 no busy", status, 8'h80);
    end
    wr(8'h90); chk("R5 back in ready", rd_sel, 2);
    wr(8'hBC); wr(8'hD0);
    chk("R5 blank check", {op_start, op_kind}, {1'b1, 3'd6});
    chk("R5 blank no busy", status, 8'h80);
    wr(8'h60); wr(8'hFF);
    chk("R5 lock bad confirm", status, 8'hB0);
    wr(8'h50);
  endtask

  task automatic t_buffered;
    int n;
    wr(8'hE8, 2); wr(8'h01, 2); wr(8'h02, 2); wr(8'hD0, 2);
    chk("R6 buffered start", {op_start, op_kind}, {1'b1, 3'd3});
    busy_len(n); chk("R6 buffered busy", n, BUSY);
    wr(8'hE8, 2); wr(8'h01, 2); wr(8'h02, 7);
    chk("R6 mismatch flag", status, 8'h90);
    wr(8'hD0, 2); chk("R6 no start after mismatch", op_start, 0);
    wr(8'h50); chk("R6 cleared", status, 8'h80);
  endtask

  task automatic t_enhanced;
    int n;
    wr(8'h80, 3); chk("R7 setup status sel", rd_sel, 1);
    wr(8'hD0, 3); chk("R7 data phase idle", status, 8'h80);
    wr(8'h11, 3);
    chk("R7 accepted", {op_start, op_kind}, {1'b1, 3'd4});
    chk("R7 bit0 busy", status, 8'h01);
    wr(8'h22, 3); chk("R7 ignored while bit0", op_start, 0);
    wr(8'h33, 5); chk("R7 other block ignored", status, 8'h01);
    busy_len(n); chk("R7 no reload", n, BUSY - 4);
    wr(8'h55, 3); chk("R7 accepted again", op_start, 1);
    busy_len(n);
    wr(8'h44, 5); chk("R7 exit no start", op_start, 0);
    wr(8'h90); chk("R7 back in ready", rd_sel, 2);
  endtask

  task automatic t_suspend;
    int n;
    wr(8'h40); wr(8'h77);
    repeat (2) @(negedge clk);
    wr(8'hB0);
    chk("R8 suspend pulse", op_suspend, 1);
    chk("R8 program suspended", status, 8'h84);
    repeat (10) @(negedge clk);
    chk("R8 stays suspended", status, 8'h84);
    wr(8'hD0);
    chk("R8 resume pulse", op_resume, 1);
    busy_len(n); chk("R8 remaining count", n, 4);
    wr(8'h20); wr(8'hD0);
    repeat (5) @(negedge clk);
    wr(8'hB0);
    chk("R8 erase suspended", status, 8'hC0);
    wr(8'hD0); busy_len(n); chk("R8 erase remaining", n, 1);
  endtask

  task automatic t_collision;
    wr(8'h20); wr(8'hD0);
    repeat (6) @(negedge clk);
    wr(8'hB0);
    chk("R9 no suspend at completion", op_suspend, 0);
    chk("R9 completed", status, 8'h80);
  endtask

  task automatic t_susp_swallow;
    int n;
    wr(8'h20); wr(8'hD0);
    repeat (2) @(negedge clk);
    wr(8'hB0); chk("R11 suspended", status, 8'hC0);
    wr(8'h20); wr(8'hD0);
    chk("R11 D0h swallowed", op_resume, 0);
    chk("R11 still suspended", status, 8'hC0);
    wr(8'h50); chk("R10 clear in suspend no effect", status, 8'hC0);
    wr(8'hD0); chk("R11 resume after swallow", op_resume, 1);
    busy_len(n); chk("R11 remaining", n, 4);
  endtask

  task automatic t_illegal;
    wr(8'hFF);
    wr(8'h12); chk("R12 illegal keeps sel", rd_sel, 0);
    wr(8'h90); chk("R12 next swallowed", rd_sel, 0);
    wr(8'h90); chk("R12 ready again", rd_sel, 2);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_read_modes;
    t_busy_reads;
    t_otp_erase;
    t_clear;
    t_lock_blank;
    t_buffered;
    t_enhanced;
    t_suspend;
    t_collision;
    t_susp_swallow;
    t_illegal;
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule